// File: doc/BRIEF.md
# Programmable Tick Clock

This block is a timer peripheral that sits on the command path of a 16-bit processor. The processor gives a one-cycle command strobe together with two 16-bit values: an operation selector and an argument. One operation sets a rate divider, and the clock then ticks 60/divider times per second, with the interval computed from the system clock frequency parameter. A second operation returns the 16-bit tick count on a writeback output. A third operation sets a 16-bit message that goes out with an interrupt request on every tick.

Reprogramming the divider clears the tick count and restarts the interval from the cycle of the command, so software can time from a known origin. A divider of zero parks the clock. The block also drives three fixed identification words that the processor can read to discover it.

Every command takes effect at the clock edge that samples the strobe and adds no wait cycles. Read data and interrupt requests are registered and appear in the cycle after the edge that produced them.

Top module: `tick_clock`

## Requirements
- R1: A strobe with selector 0 loads the divider from the argument, clears the tick count to 0 and restarts the interval at that edge. A tick that would have fallen on that same edge is dropped, with no count change and no interrupt.
- R2: While the divider is 0 no tick occurs: the count holds and no interrupt is raised.
- R3: With a nonzero divider d, ticks fall on the edges t+k·P, k ≥ 1, where t is the configuring edge and P = SYS_CLK_HZ·d/60 cycles, using integer division.
- R4: A strobe with selector 1 makes `readValid` high for exactly the next cycle, with `readData` holding the tick count. The count, the divider and the message are left unchanged.
- R5: A strobe with selector 2 loads the interrupt message from the argument. A message of 0 suppresses interrupts.
- R6: Each tick adds 1 to the 16-bit count, and the count wraps from 0xFFFF to 0x0000.
- R7: For each tick with a nonzero message, `irqValid` is high for the one cycle after the tick edge, and `irqMsg` equals the message.
- R8: A strobe with any selector above 2 changes nothing: no read pulse, no count change, and the rate and message stay as they were.
- R9: `hwId` is 0x12D0B402, `hwVersion` is 1 and `hwVendor` is 0 at all times.
- R10: Reset clears the divider, the count and the message to 0, and both `readValid` and `irqValid` are low.
- R11: When a read strobe and a tick fall on the same edge, `readData` shows the count from before that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdSel | input | 16 | Operation selector |
| cmdArg | input | 16 | Operation argument |
| readValid | output | 1 | Writeback data valid |
| readData | output | 16 | Tick count writeback |
| irqValid | output | 1 | Interrupt request pulse |
| irqMsg | output | 16 | Message carried by the interrupt |
| hwId | output | 32 | Fixed hardware identifier |
| hwVersion | output | 16 | Fixed hardware version |
| hwVendor | output | 32 | Fixed vendor identifier |

## Verification
The hardest case to reach from the ports is the count wrapping past 0xFFFF, which needs 65536 ticks. The bench sets the system clock parameter to 60 Hz so that the interval equals the divider in cycles. With a divider of 1 the wrap then comes within about 65 thousand cycles. The same divider puts a tick on every edge, so each read lands on a tick edge and exercises R11. Random dividers, waits and messages, with zero messages among them, then compare the count and the number of interrupts against a closed-form expectation taken from the configuring edge.

// File: rtl/tick_clock_pkg.sv
package tick_clock_pkg;

  localparam logic [15:0] SEL_SET_RATE = 16'd0;
  localparam logic [15:0] SEL_READ_CNT = 16'd1;
  localparam logic [15:0] SEL_SET_MSG  = 16'd2;

  localparam logic [31:0] ID_WORD      = 32'h12D0_B402;
  localparam logic [15:0] VERSION_WORD = 16'd1;
  localparam logic [31:0] VENDOR_WORD  = 32'd0;

  typedef struct packed {
    logic loadDiv;
    logic readCnt;
    logic loadMsg;
    logic tick;
  } clkStrobes_t;

endpackage

// File: rtl/tick_clock_ctrl.sv
module tick_clock_ctrl
  import tick_clock_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              cmdValid,
  input  logic [DATA_W-1:0] cmdSel,
  input  logic              periodHit,
  input  logic              divIsZero,
  output clkStrobes_t       strobes
);

  logic selRate, selRead, selMsg;

  always_comb begin
    selRate = cmdValid && (cmdSel == DATA_W'(SEL_SET_RATE));
    selRead = cmdValid && (cmdSel == DATA_W'(SEL_READ_CNT));
    selMsg  = cmdValid && (cmdSel == DATA_W'(SEL_SET_MSG));
    strobes.loadDiv = selRate;
    strobes.readCnt = selRead;
    strobes.loadMsg = selMsg;
    // reprogramming on the same edge wins over a pending tick
    strobes.tick    = periodHit && !divIsZero && !selRate;
  end

endmodule

// File: rtl/tick_clock_dp.sv
module tick_clock_dp
  import tick_clock_pkg::*;
#(
  parameter longint SYS_CLK_HZ = 600,
  parameter int     DATA_W     = 16,
  parameter int     PERIOD_W   = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  clkStrobes_t       strobes,
  input  logic [DATA_W-1:0] cmdArg,
  output logic              periodHit,
  output logic              divIsZero,
  output logic [DATA_W-1:0] curCount,
  output logic              readValid,
  output logic [DATA_W-1:0] readData,
  output logic              irqValid,
  output logic [DATA_W-1:0] irqMsg
);

  localparam int PROD_W = 64;
  localparam logic [PROD_W-1:0] TICKS_PER_SEC = PROD_W'(60);

  logic [DATA_W-1:0]   divider;
  logic [DATA_W-1:0]   message;
  logic [PERIOD_W-1:0] period;
  logic [PERIOD_W-1:0] cycleCnt;
  logic [PERIOD_W-1:0] periodNext;
  logic [PROD_W-1:0]   product;
  logic [PROD_W-1:0]   quotient;

  always_comb begin
    product  = PROD_W'(SYS_CLK_HZ) * PROD_W'(cmdArg);
    quotient = product / TICKS_PER_SEC;
    periodNext = PERIOD_W'(quotient);
    if (periodNext == '0) periodNext = PERIOD_W'(1);
  end

  assign divIsZero = (divider == '0);
  assign periodHit = (cycleCnt == period - PERIOD_W'(1));

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divider <= '0;
      period  <= PERIOD_W'(1);
      message <= '0;
    end else begin
      if (strobes.loadDiv) begin
        divider <= cmdArg;
        period  <= periodNext;
      end
      if (strobes.loadMsg) message <= cmdArg;
    end
  end

  // interval counter
  always_ff @(posedge clk) begin
    if (!rstN)                    cycleCnt <= '0;
    else if (strobes.loadDiv)     cycleCnt <= '0;
    else if (divIsZero)           cycleCnt <= '0;
    else if (periodHit)           cycleCnt <= '0;
    else                          cycleCnt <= cycleCnt + PERIOD_W'(1);
  end

  // tick count, wraps naturally
  always_ff @(posedge clk) begin
    if (!rstN)                curCount <= '0;
    else if (strobes.loadDiv) curCount <= '0;
    else if (strobes.tick)    curCount <= curCount + DATA_W'(1);
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readValid <= 1'b0;
      readData  <= '0;
      irqValid  <= 1'b0;
      irqMsg    <= '0;
    end else begin
      readValid <= strobes.readCnt;
      if (strobes.readCnt) readData <= curCount;
      irqValid  <= strobes.tick && (message != '0);
      if (strobes.tick) irqMsg <= message;
    end
  end

endmodule

// File: rtl/tick_clock.sv
module tick_clock
  import tick_clock_pkg::*;
#(
  parameter longint SYS_CLK_HZ = 600,
  parameter int     PERIOD_W   = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdSel,
  input  logic [15:0] cmdArg,
  output logic        readValid,
  output logic [15:0] readData,
  output logic        irqValid,
  output logic [15:0] irqMsg,
  output logic [31:0] hwId,
  output logic [15:0] hwVersion,
  output logic [31:0] hwVendor
);

  localparam int DATA_W = 16;

  clkStrobes_t       strobes;
  logic              periodHit;
  logic              divIsZero;
  logic [DATA_W-1:0] curCount;

  tick_clock_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .cmdValid (cmdValid),
    .cmdSel   (cmdSel),
    .periodHit(periodHit),
    .divIsZero(divIsZero),
    .strobes  (strobes)
  );

  tick_clock_dp #(
    .SYS_CLK_HZ(SYS_CLK_HZ),
    .DATA_W    (DATA_W),
    .PERIOD_W  (PERIOD_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmdArg   (cmdArg),
    .periodHit(periodHit),
    .divIsZero(divIsZero),
    .curCount (curCount),
    .readValid(readValid),
    .readData (readData),
    .irqValid (irqValid),
    .irqMsg   (irqMsg)
  );

  assign hwId      = ID_WORD;
  assign hwVersion = VERSION_WORD;
  assign hwVendor  = VENDOR_WORD;

endmodule

// File: rtl/tick_clock_checker.sv
module tick_clock_checker
  import tick_clock_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [15:0] cmdSel,
  input logic        readValid,
  input logic [15:0] readData,
  input logic        irqValid,
  input logic [15:0] irqMsg,
  input clkStrobes_t strobes,
  input logic        divIsZero,
  input logic [15:0] curCount
);

  // R1: configuration clears the count
  p_cfg_clears_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadDiv |=> (curCount == 16'd0));

  // R2: parked clock never ticks
  p_parked_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    divIsZero |-> !strobes.tick);

  // R6: tick increments with wrap
  p_tick_increments_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.loadDiv) |=> (curCount == $past(curCount) + 16'd1));

  // R4 and R11: read returns the pre-edge count
  p_read_returns_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdSel == SEL_READ_CNT) |=> (readValid && readData == $past(curCount)));

  // R5: a raised interrupt never carries a zero message
  p_irq_nonzero_msg_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqMsg != 16'd0));

  // R8: unknown selectors leave the count alone
  p_unknown_sel_inert_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdSel > 16'd2 && !strobes.tick) |=> $stable(curCount));

endmodule

bind tick_clock tick_clock_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdSel   (cmdSel),
  .readValid(readValid),
  .readData (readData),
  .irqValid (irqValid),
  .irqMsg   (irqMsg),
  .strobes  (strobes),
  .divIsZero(divIsZero),
  .curCount (curCount)
);

// File: tb/tick_clock_test.sv
module tick_clock_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdSel = '0;
  logic [15:0] cmdArg = '0;
  logic        readValid;
  logic [15:0] readData;
  logic        irqValid;
  logic [15:0] irqMsg;
  logic [31:0] hwId;
  logic [15:0] hwVersion;
  logic [31:0] hwVendor;

  // 60 Hz system clock parameter: interval in cycles equals the divider
  tick_clock #(.SYS_CLK_HZ(60)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSel(cmdSel), .cmdArg(cmdArg),
    .readValid(readValid), .readData(readData), .irqValid(irqValid), .irqMsg(irqMsg),
    .hwId(hwId), .hwVersion(hwVersion), .hwVendor(hwVendor)
  );

  always #2.5 clk = ~clk;

  int     checks = 0;
  int     fails = 0;
  bit     done = 1'b0;
  longint edgeCnt = 0;
  longint irqSeen = 0;
  longint irqBase = 0;
  longint cfgEdge = 0;
  int     curDiv = 0;
  logic [15:0] curMsg = '0;
  bit     prevIrq = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count interrupts; values seen here are from the cycle before the edge
  always @(posedge clk) begin
    edgeCnt <= edgeCnt + 1;
    if (rstN && irqValid) begin
      irqSeen <= irqSeen + 1;
      check(irqMsg == curMsg, "R7 irq message", irqMsg, curMsg);
      if (curDiv >= 2) check(!prevIrq, "R7 single-cycle pulse", prevIrq, 0);
    end
    prevIrq <= rstN && irqValid;
  end

  function automatic longint expTicks(longint e, longint t, int d);
    if (d == 0) return 0;
    return (e - 1 - t) / d;
  endfunction

  task automatic doCmd(input logic [15:0] a, input logic [15:0] b, output longint e);
    @(negedge clk);
    cmdValid = 1'b1; cmdSel = a; cmdArg = b;
    @(negedge clk);
    cmdValid = 1'b0;
    e = edgeCnt;
  endtask

  task automatic configure(input int d);
    longint e;
    doCmd(16'd0, 16'(d), e);
    cfgEdge = e; curDiv = d; irqBase = irqSeen;
  endtask

  task automatic setMsg(input logic [15:0] m);
    longint e;
    configure(0);
    doCmd(16'd2, m, e);
    curMsg = m;
  endtask

  task automatic readAndCheck(input string req);
    longint e;
    longint expT;
    doCmd(16'd1, 16'hBEEF, e);
    expT = expTicks(e, cfgEdge, curDiv);
    check(readValid == 1'b1, {req, " read valid"}, readValid, 1);
    check(readData == 16'(expT), {req, " count"}, readData, expT & 64'hFFFF);
    check((irqSeen - irqBase) == ((curMsg != 0) ? expT : 0), {req, " irq total"},
          irqSeen - irqBase, (curMsg != 0) ? expT : 0);
  endtask

  initial begin
    longint e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(readValid == 1'b0, "R10 readValid low", readValid, 0);
    check(irqValid == 1'b0, "R10 irqValid low", irqValid, 0);
    rstN = 1'b1;
    // R9 identification
    check(hwId == 32'h12D0B402, "R9 hwId", hwId, 32'h12D0B402);
    check(hwVersion == 16'd1, "R9 hwVersion", hwVersion, 1);
    check(hwVendor == 32'd0, "R9 hwVendor", hwVendor, 0);
    // R10 count is zero and R2 the parked clock stays at zero
    cfgEdge = edgeCnt; curDiv = 0;
    repeat (40) @(negedge clk);
    readAndCheck("R10 R2 parked after reset");
    check(readValid == 1'b1, "R4 read pulse", readValid, 1);
    @(negedge clk);
    check(readValid == 1'b0, "R4 pulse is one cycle", readValid, 0);

    // R3 R6 R7 directed rate with message
    setMsg(16'h00A5);
    configure(3);
    repeat (31) @(negedge clk);
    readAndCheck("R3 divider 3");

    // R8 unknown selector, then check rate and message still hold
    doCmd(16'd7, 16'h0000, e);
    check(readValid == 1'b0, "R8 no read pulse", readValid, 0);
    doCmd(16'hFFFF, 16'h1234, e);
    repeat (5) @(negedge clk);
    readAndCheck("R8 unknown selector inert");

    // R11 divider 1 ticks on every edge, including the read edge
    configure(1);
    repeat (9) @(negedge clk);
    readAndCheck("R11 read on tick edge");

    // R1 reprogramming restarts the count
    configure(2);
    readAndCheck("R1 immediate read after config");
    repeat (7) @(negedge clk);
    readAndCheck("R1 count after restart");

    // R2 parking stops ticks and interrupts
    configure(0);
    repeat (30) @(negedge clk);
    readAndCheck("R2 parked");

    // R5 zero message suppresses interrupts
    setMsg(16'h0000);
    configure(2);
    repeat (20) @(negedge clk);
    readAndCheck("R5 zero message");

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [15:0] m;
      int d;
      m = ($urandom % 4 == 0) ? 16'h0000 : 16'($urandom);
      d = 1 + int'($urandom % 20);
      setMsg(m);
      configure(d);
      repeat (int'($urandom % 120)) @(negedge clk);
      readAndCheck("R3 R5 R7 random");
      repeat (int'($urandom % 40)) @(negedge clk);
      readAndCheck("R4 R6 random reread");
    end

    // R6 wrap past 0xFFFF
    setMsg(16'h0000);
    configure(1);
    repeat (65540) @(negedge clk);
    readAndCheck("R6 wrap");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", edgeCnt, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule